// File: doc/BRIEF.md
# DMA Error Capture and Interrupt Unit

This block sits beside the channel sequencer of a multi-channel DMA engine and turns raw fault strobes into a readable error record. Six fault classes are told apart: a bus error while a descriptor is fetched or written back, a bus error while the channel vector table is accessed, a failed conditional poll, a conditional retry count above its limit, a conditional event count above its limit, and a timeout of triggered conditional execution. The two limit faults come from comparing a running count against a programmable maximum on a check strobe. The timeout fault counts only while timeout checking is switched on.

On any fault the block sets the class bit and a summary error flag, and it records the channel on which the first fault occurred. While the summary flag is set, the sequencer is told to halt every channel. If both the global interrupt enable and the error interrupt enable are on, the flag of the failing channel is set, and the interrupt output is the OR of all channel flags. Software reads two words over a simple register port and clears bits by writing ones.

Top module: `dma_err_capture`

## Requirements
- R1: The status word (address 0) holds the summary flag in bit 0 and the class bits in bits 1 to 6: bit 1 descriptor access, bit 2 vector table access, bit 3 conditional poll, bit 4 retry limit, bit 5 count limit, bit 6 timeout. Bits 7 and any bits above the channel field read as zero.
- R2: A fault strobe sampled at a clock edge sets its class bit and the summary flag. Both are visible on `reg_rdata` right after that edge. Faults of several classes in one cycle set all of their bits.
- R3: A retry-limit or count-limit fault fires only when its check strobe is high and the count is strictly greater than the maximum. A count equal to the maximum raises nothing.
- R4: A timeout strobe raises a fault only while `cfg_tmo_en` is 1. Otherwise it changes no register and no output.
- R5: The channel field, starting at bit 8 of the status word, captures `ev_chan` of a fault that arrives while the summary flag is clear. Later faults leave it unchanged. It keeps its value after the flag is cleared, until the next capture.
- R6: A fault sets flag bit `ev_chan` of the channel flag word (address 1) only when `cfg_irq_en` and `cfg_err_irq_en` are both 1. `irq` is high whenever any channel flag is set.
- R7: `halt` is high from the edge that sets the summary flag until the flag is cleared.
- R8: A write to address 0 clears each of bits 0 to 6 whose data bit is 1. A write to address 1 clears each channel flag whose data bit is 1. Zero data bits leave their bits alone. A fault in the same cycle as a clear leaves its bits set.
- R9: After reset both words read zero, and `irq` and `halt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_desc | input | 1 | Bus error on a descriptor read or write-back |
| ev_vec | input | 1 | Bus error on a channel vector table access |
| ev_cond | input | 1 | Conditional poll failure |
| retry_chk | input | 1 | Compare retry count against its limit this cycle |
| retry_cnt | input | CNT_W | Current retry count |
| retry_max | input | CNT_W | Retry limit |
| count_chk | input | 1 | Compare conditional count against its limit this cycle |
| count_cnt | input | CNT_W | Current conditional count |
| count_max | input | CNT_W | Conditional count limit |
| tmo_expire | input | 1 | Timeout counter expired during triggered execution |
| ev_chan | input | CH_W | Channel active when the strobe fires |
| cfg_irq_en | input | 1 | Global interrupt enable |
| cfg_err_irq_en | input | 1 | Interrupt on error enable |
| cfg_tmo_en | input | 1 | Timeout checking enable |
| reg_wr | input | 1 | Register write strobe (write one to clear) |
| reg_addr | input | 1 | 0: status word, 1: channel flag word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| halt | output | 1 | Halt request to the channel sequencer |

## Verification
The bench builds the block with eight channels and 4-bit counters. With eight channels the channel field and the flag word use their top bits: channel 7 and flag bit 7 are both checked. With 4-bit counters the all-ones value 15 can be used as a count and as a limit, so the bench checks that a count of 15 against a limit of 15 stays quiet and against a limit of 14 fires. It also drives a clear and a fault in the same cycle, and it drives faults with each enable off.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    localparam int N_CLS      = 6;
    localparam int REG_W      = 32;
    localparam int TYPE_LSB   = 1;
    localparam int CHAN_LSB   = 8;
    localparam int CHAN_MAX_W = REG_W - CHAN_LSB;
    localparam int N_LIMIT    = 2;

    typedef enum int unsigned {
        CLS_DESC  = 0,
        CLS_VEC   = 1,
        CLS_COND  = 2,
        CLS_RETRY = 3,
        CLS_COUNT = 4,
        CLS_TMO   = 5
    } err_cls_e;

    typedef logic [N_CLS-1:0] cls_vec_t;

    typedef struct packed {
        cls_vec_t types;
        logic     e;
    } err_flags_t;

    localparam int FLAG_W = $bits(err_flags_t);

    function automatic logic [REG_W-1:0] pack_status(err_flags_t f,
                                                     logic [CHAN_MAX_W-1:0] ch);
        logic [REG_W-1:0] w;
        w = '0;
        w[FLAG_W-1:0] = f;
        w[REG_W-1:CHAN_LSB] = ch;
        return w;
    endfunction

endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lim,
    output logic             hit
);

    always_comb hit = chk && (cnt > lim);

    // R3
    no_fire_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt <= lim) |-> !hit);

endmodule

// File: rtl/err_classify.sv
module err_classify
    import dma_err_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_desc,
    input  logic             ev_vec,
    input  logic             ev_cond,
    input  logic             retry_chk,
    input  logic [CNT_W-1:0] retry_cnt,
    input  logic [CNT_W-1:0] retry_max,
    input  logic             count_chk,
    input  logic [CNT_W-1:0] count_cnt,
    input  logic [CNT_W-1:0] count_max,
    input  logic             tmo_expire,
    input  logic             tmo_en,
    output cls_vec_t         cls
);

    logic [N_LIMIT-1:0]            lim_chk;
    logic [N_LIMIT-1:0][CNT_W-1:0] lim_cnt;
    logic [N_LIMIT-1:0][CNT_W-1:0] lim_max;
    logic [N_LIMIT-1:0]            lim_hit;

    always_comb begin
        lim_chk = {count_chk, retry_chk};
        lim_cnt = {count_cnt, retry_cnt};
        lim_max = {count_max, retry_max};
    end

    for (genvar g = 0; g < N_LIMIT; g++) begin : g_lim
        limit_cmp #(.CNT_W(CNT_W)) cmp_i (
            .clk (clk),
            .rst (rst),
            .chk (lim_chk[g]),
            .cnt (lim_cnt[g]),
            .lim (lim_max[g]),
            .hit (lim_hit[g])
        );
    end

    always_comb begin
        cls            = '0;
        cls[CLS_DESC]  = ev_desc;
        cls[CLS_VEC]   = ev_vec;
        cls[CLS_COND]  = ev_cond;
        cls[CLS_RETRY] = lim_hit[0];
        cls[CLS_COUNT] = lim_hit[1];
        cls[CLS_TMO]   = tmo_expire && tmo_en;
    end

    // R4
    tmo_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !tmo_en |-> !cls[CLS_TMO]);

endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
    import dma_err_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  cls_vec_t        cls,
    input  logic [CH_W-1:0] ev_chan,
    input  err_flags_t      clr,
    output err_flags_t      flags_q,
    output logic [CH_W-1:0] chan_q
);

    logic       any_err;
    err_flags_t flags_d;

    always_comb begin
        any_err       = |cls;
        flags_d.types = (flags_q.types & ~clr.types) | cls;
        flags_d.e     = (flags_q.e & ~clr.e) | any_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            chan_q  <= '0;
        end else begin
            flags_q <= flags_d;
            if (any_err && !flags_q.e) begin
                chan_q <= ev_chan;
            end
        end
    end

    // R2
    set_on_event_chk: assert property (@(posedge clk) disable iff (rst)
        (|cls) |=> flags_q.e);

    // R5
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        flags_q.e |=> $stable(chan_q));

    // R8
    clear_e_chk: assert property (@(posedge clk) disable iff (rst)
        (clr.e && !(|cls)) |=> !flags_q.e);

endmodule

// File: rtl/chan_irq_flags.sv
module chan_irq_flags #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_err,
    input  logic [CH_W-1:0]   ev_chan,
    input  logic              glb_en,
    input  logic              err_en,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] flags_q,
    output logic              irq
);

    logic raise;

    always_comb raise = any_err && glb_en && err_en;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[c] <= 1'b0;
            end else if (raise && (ev_chan == CH_W'(c))) begin
                flags_q[c] <= 1'b1;
            end else if (clr[c]) begin
                flags_q[c] <= 1'b0;
            end
        end
    end

    always_comb irq = |flags_q;

    // R6
    no_flag_when_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !(glb_en && err_en) |=> ((flags_q & ~$past(flags_q)) == '0));

endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
    import dma_err_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_desc,
    input  logic             ev_vec,
    input  logic             ev_cond,
    input  logic             retry_chk,
    input  logic [CNT_W-1:0] retry_cnt,
    input  logic [CNT_W-1:0] retry_max,
    input  logic             count_chk,
    input  logic [CNT_W-1:0] count_cnt,
    input  logic [CNT_W-1:0] count_max,
    input  logic             tmo_expire,
    input  logic [CH_W-1:0]  ev_chan,
    input  logic             cfg_irq_en,
    input  logic             cfg_err_irq_en,
    input  logic             cfg_tmo_en,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             halt
);

    cls_vec_t          cls;
    err_flags_t        st_clr;
    err_flags_t        st_q;
    logic [CH_W-1:0]   chan_q;
    logic [NUM_CH-1:0] fl_clr;
    logic [NUM_CH-1:0] fl_q;

    err_classify #(.CNT_W(CNT_W)) cls_i (
        .clk        (clk),
        .rst        (rst),
        .ev_desc    (ev_desc),
        .ev_vec     (ev_vec),
        .ev_cond    (ev_cond),
        .retry_chk  (retry_chk),
        .retry_cnt  (retry_cnt),
        .retry_max  (retry_max),
        .count_chk  (count_chk),
        .count_cnt  (count_cnt),
        .count_max  (count_max),
        .tmo_expire (tmo_expire),
        .tmo_en     (cfg_tmo_en),
        .cls        (cls)
    );

    always_comb begin
        st_clr = (reg_wr && !reg_addr) ? err_flags_t'(reg_wdata[FLAG_W-1:0]) : '0;
        fl_clr = (reg_wr &&  reg_addr) ? reg_wdata[NUM_CH-1:0] : '0;
    end

    err_status_reg #(.CH_W(CH_W)) st_i (
        .clk     (clk),
        .rst     (rst),
        .cls     (cls),
        .ev_chan (ev_chan),
        .clr     (st_clr),
        .flags_q (st_q),
        .chan_q  (chan_q)
    );

    chan_irq_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W)) fl_i (
        .clk     (clk),
        .rst     (rst),
        .any_err (|cls),
        .ev_chan (ev_chan),
        .glb_en  (cfg_irq_en),
        .err_en  (cfg_err_irq_en),
        .clr     (fl_clr),
        .flags_q (fl_q),
        .irq     (irq)
    );

    always_comb begin
        halt = st_q.e;
        if (reg_addr) begin
            reg_rdata = REG_W'(fl_q);
        end else begin
            reg_rdata = pack_status(st_q, CHAN_MAX_W'(chan_q));
        end
    end

    // R7
    halt_after_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_desc || ev_vec || ev_cond) |=> halt);

endmodule

// File: tb/dma_err_capture_tb_top.sv
`timescale 1ns/1ps
module dma_err_capture_tb_top;

    localparam int NUM_CH = 8;
    localparam int CNT_W  = 4;
    localparam int CH_W   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ev_desc = 0, ev_vec = 0, ev_cond = 0;
    logic             retry_chk = 0, count_chk = 0, tmo_expire = 0;
    logic [CNT_W-1:0] retry_cnt = '0, retry_max = '0, count_cnt = '0, count_max = '0;
    logic [CH_W-1:0]  ev_chan = '0;
    logic             cfg_irq_en = 0, cfg_err_irq_en = 0, cfg_tmo_en = 0;
    logic             reg_wr = 0, reg_addr = 0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             irq, halt;

    always #2 clk = ~clk;

    dma_err_capture #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst),
        .ev_desc(ev_desc), .ev_vec(ev_vec), .ev_cond(ev_cond),
        .retry_chk(retry_chk), .retry_cnt(retry_cnt), .retry_max(retry_max),
        .count_chk(count_chk), .count_cnt(count_cnt), .count_max(count_max),
        .tmo_expire(tmo_expire), .ev_chan(ev_chan),
        .cfg_irq_en(cfg_irq_en), .cfg_err_irq_en(cfg_err_irq_en), .cfg_tmo_en(cfg_tmo_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .halt(halt)
    );

    typedef struct {
        logic        addr;
        logic [31:0] data;
        logic        irq;
        logic        halt;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // status word built from R1/R5 layout
    function automatic logic [31:0] st(bit e, logic [5:0] t, int ch);
        return 32'(e) | (32'(t) << 1) | (32'(ch) << 8);
    endfunction

    // monitor: compares one queued expectation per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_checks++;
            if (reg_rdata !== x.data || irq !== x.irq || halt !== x.halt) begin
                n_fail++;
                $display("FAIL %s addr=%0d: rdata=%h irq=%b halt=%b expected rdata=%h irq=%b halt=%b",
                         x.req, x.addr, reg_rdata, irq, halt, x.data, x.irq, x.halt);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ev_desc = 0; ev_vec = 0; ev_cond = 0;
        retry_chk = 0; count_chk = 0; tmo_expire = 0;
        reg_wr = 0;
    endtask

    // driver: push expectation for the current read address
    task automatic expect_rd(logic a, logic [31:0] d, logic i, logic h, string r);
        exp_t x;
        reg_addr = a;
        x.addr = a; x.data = d; x.irq = i; x.halt = h; x.req = r;
        exp_q.push_back(x);
        tick();
    endtask

    task automatic w1c(logic a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        idle();
    endtask

    task automatic clear_all();
        w1c(1'b0, 32'h7F);
        w1c(1'b1, 32'hFF);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R9 reset state
        expect_rd(0, 32'h0, 0, 0, "R9 status after reset");
        expect_rd(1, 32'h0, 0, 0, "R9 flags after reset");

        cfg_irq_en = 1; cfg_err_irq_en = 1;

        // R1 R2 R5 R6 R7: descriptor fault on channel 5
        ev_desc = 1; ev_chan = 5; tick(); idle();
        expect_rd(0, st(1, 6'h01, 5), 1, 1, "R1 R2 R5 R7 descriptor fault");
        expect_rd(1, 32'h20, 1, 1, "R6 flag of channel 5");

        // R5: later fault on channel 7 keeps channel 5
        ev_vec = 1; ev_chan = 7; tick(); idle();
        expect_rd(0, st(1, 6'h03, 5), 1, 1, "R5 first channel kept");
        expect_rd(1, 32'hA0, 1, 1, "R6 flag of channel 7");

        // R8 write-one-to-clear
        w1c(0, 32'h7F);
        expect_rd(0, st(0, 6'h00, 5), 1, 0, "R8 R7 status cleared");
        w1c(1, 32'h80);
        expect_rd(1, 32'h20, 1, 0, "R8 partial flag clear");
        w1c(1, 32'h20);
        expect_rd(1, 32'h00, 0, 0, "R8 R6 flags cleared");

        // R4 timeout ignored when disabled
        tmo_expire = 1; ev_chan = 3; tick(); idle();
        expect_rd(0, st(0, 6'h00, 5), 0, 0, "R4 timeout masked status");
        expect_rd(1, 32'h00, 0, 0, "R4 timeout masked flags");
        cfg_tmo_en = 1;
        tmo_expire = 1; ev_chan = 3; tick(); idle();
        expect_rd(0, st(1, 6'h20, 3), 1, 1, "R4 timeout enabled");
        expect_rd(1, 32'h08, 1, 1, "R6 flag of channel 3");
        clear_all();

        // R3 retry limit, strict compare
        retry_chk = 1; retry_cnt = 9; retry_max = 9; ev_chan = 1; tick(); idle();
        expect_rd(0, st(0, 6'h00, 3), 0, 0, "R3 retry equal to limit");
        retry_chk = 1; retry_cnt = 10; retry_max = 9; ev_chan = 1; tick(); idle();
        expect_rd(0, st(1, 6'h08, 1), 1, 1, "R3 retry above limit");
        retry_cnt = 15; retry_max = 2; tick();
        expect_rd(0, st(1, 6'h08, 1), 1, 1, "R3 no check strobe no change");
        clear_all();

        // R3 count limit at all-ones
        count_chk = 1; count_cnt = 15; count_max = 15; ev_chan = 0; tick(); idle();
        expect_rd(0, st(0, 6'h00, 1), 0, 0, "R3 count equal all-ones limit");
        count_chk = 1; count_cnt = 15; count_max = 14; ev_chan = 0; tick(); idle();
        expect_rd(0, st(1, 6'h10, 0), 1, 1, "R3 count above limit");
        expect_rd(1, 32'h01, 1, 1, "R6 flag of channel 0");
        clear_all();

        // R6 masked by each enable
        cfg_err_irq_en = 0;
        ev_cond = 1; ev_chan = 6; tick(); idle();
        expect_rd(0, st(1, 6'h04, 6), 0, 1, "R6 error enable off status");
        expect_rd(1, 32'h00, 0, 1, "R6 error enable off flags");
        clear_all();
        cfg_err_irq_en = 1; cfg_irq_en = 0;
        ev_cond = 1; ev_chan = 2; tick(); idle();
        expect_rd(1, 32'h00, 0, 1, "R6 global enable off flags");
        clear_all();
        cfg_irq_en = 1;

        // R8 partial status clear
        ev_desc = 1; ev_chan = 4; tick(); idle();
        w1c(0, 32'h02);
        expect_rd(0, st(1, 6'h00, 4), 1, 1, "R8 type cleared, flag kept");
        w1c(0, 32'h01);
        expect_rd(0, st(0, 6'h00, 4), 1, 0, "R8 R5 flag cleared, channel held");
        w1c(1, 32'hFF);

        // R8 fault wins over same-cycle clear
        ev_desc = 1; ev_chan = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h7F; tick(); idle();
        expect_rd(0, st(1, 6'h01, 1), 1, 1, "R8 set wins over clear");
        ev_vec = 1; ev_chan = 2; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h7F; tick(); idle();
        expect_rd(0, st(1, 6'h02, 1), 1, 1, "R8 R5 clear with new fault");
        clear_all();

        // R2 several classes in one cycle
        ev_desc = 1; ev_cond = 1; ev_chan = 7; tick(); idle();
        expect_rd(0, st(1, 6'h05, 7), 1, 1, "R2 simultaneous classes");
        expect_rd(1, 32'h80, 1, 1, "R6 flag of channel 7 alone");

        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule